// File: doc/BRIEF.md
# Two-Word Control Port Decoder

This block sits behind the 16-bit control port of a video processor. Each word written there is sorted into one of two kinds. One kind is an immediate write to the processor's internal register file. The other kind is one half of a two-word access command. The command builds a 16-bit access address and a 6-bit access code, and its bits are spread across the two words. A pending flag records that the first half has arrived. While that flag is set, the next control word is taken as the second half, whatever bits it carries.

The pending flag is dropped by any data-port write, any data-port read, or any control-port read. When one of these accesses arrives in the same cycle as a control write, the flag is dropped first and the control word is then decoded as if nothing were pending. The block also forms the status word returned on control-port reads, which carries the write FIFO's empty and full state. It flags a data-port read that meets a write-type access code, so the caller returns zero without touching memory.

Top module: `cmdport_decoder`

## Requirements
- R1: After reset, acc_addr and acc_code are zero, cmd_pending is low and reg_we is low.
- R2: With no command pending, a control write whose bits 15:14 are binary 10 and whose bits 12:8 hold an index below NUM_REGS (default 24) pulses reg_we for exactly one cycle on the clock after the strobe. In that cycle reg_idx equals bits 12:8 and reg_wdata equals bits 7:0.
- R3: A register-write word whose index (bits 12:8) is NUM_REGS or greater produces no reg_we pulse.
- R4: A register-write word, accepted or ignored, leaves acc_addr and acc_code unchanged and leaves cmd_pending low.
- R5: With no command pending, a control write whose bits 15:14 are not binary 10 sets cmd_pending and copies bits 13:0 into acc_addr[13:0] and bits 15:14 into acc_code[1:0]. acc_addr[15:14] and acc_code[5:2] keep their values.
- R6: With a command pending, any control write, including one whose top bits are binary 10, copies bits 1:0 into acc_addr[15:14] and bits 7:4 into acc_code[5:2], and clears cmd_pending. The other address and code bits keep their values.
- R7: A data-port write, a data-port read or a control-port read clears cmd_pending on the next clock and leaves acc_addr and acc_code unchanged.
- R8: When a clearing access and a control write fall in the same cycle, the control word is decoded as if no command were pending (R2, R3 or R5).
- R9: stat_rdata is 0x3400 with bit 9 set while fifo_empty is high and bit 8 set while fifo_full is high, with no clock delay.
- R10: rd_zero is high, with no clock delay, exactly when dat_rd is high and acc_code bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control-port write word |
| ctl_rd | input | 1 | Control-port read strobe |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| fifo_empty | input | 1 | Write FIFO holds no entries |
| fifo_full | input | 1 | Write FIFO has no free entry |
| stat_rdata | output | 16 | Status word for control-port reads |
| reg_we | output | 1 | Register-file write enable, one cycle |
| reg_idx | output | 5 | Register-file index |
| reg_wdata | output | 8 | Register-file write byte |
| acc_addr | output | 16 | Access address register |
| acc_code | output | 6 | Access code register |
| cmd_pending | output | 1 | First command word received, second awaited |
| rd_zero | output | 1 | Data read must return zero |

## Verification
A control write and a pending-clearing access can land in the same cycle, and the result then depends on the order in which the two are applied. The random phase draws the control, data and status strobes independently for each cycle, so these collisions happen many times, both with and without a command pending. Directed cases also pair a data read with a first word, and a control read with a register-write word, while a command is pending. The bench model clears the flag first and then decodes the word. It then compares reg_we, the address, the code and the pending flag after the next edge.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 6;
  localparam int IDX_W    = 5;
  localparam int BYTE_W   = 8;
  localparam int LO_ADR_W = 14;
  localparam int HI_ADR_W = WORD_W - LO_ADR_W;
  localparam int LO_CODE_W = 2;
  localparam int HI_CODE_W = CODE_W - LO_CODE_W;
  localparam int IDX_LSB  = 8;
  localparam int HI_CODE_LSB = 4;
  localparam logic [1:0] REGWR_TAG = 2'b10;
  localparam logic [WORD_W-1:0] STAT_BASE = 16'h3400;
  localparam int EMPTY_BIT = 9;
  localparam int FULL_BIT  = 8;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_REGWR  = 2'd1,
    WK_FIRST  = 2'd2,
    WK_SECOND = 2'd3
  } word_kind_e;

  typedef struct packed {
    logic              we;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] data;
  } regwr_t;
endpackage

// File: rtl/cmdport_rst_sync.sv
module cmdport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/cmdport_cmd_regs.sv
module cmdport_cmd_regs
  import cmdport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              clr_stb,
  output word_kind_e        kind,
  output logic [WORD_W-1:0] addr_q,
  output logic [CODE_W-1:0] code_q,
  output logic              pend_q
);
  logic              pend_eff;
  logic [WORD_W-1:0] addr_nx;
  logic [CODE_W-1:0] code_nx;
  logic              pend_nx;
  logic              upd_en;

  // A clearing access in the same cycle is applied before decoding
  assign pend_eff = pend_q & ~clr_stb;

  always_comb begin
    kind = WK_NONE;
    if (wr_stb) begin
      if (pend_eff)                                       kind = WK_SECOND;
      else if (wr_word[WORD_W-1 -: 2] == REGWR_TAG)        kind = WK_REGWR;
      else                                                kind = WK_FIRST;
    end
  end

  always_comb begin
    addr_nx = addr_q;
    code_nx = code_q;
    pend_nx = pend_eff;
    case (kind)
      WK_FIRST: begin
        addr_nx[LO_ADR_W-1:0]  = wr_word[LO_ADR_W-1:0];
        code_nx[LO_CODE_W-1:0] = wr_word[WORD_W-1 -: LO_CODE_W];
        pend_nx = 1'b1;
      end
      WK_SECOND: begin
        addr_nx[WORD_W-1 -: HI_ADR_W] = wr_word[HI_ADR_W-1:0];
        code_nx[CODE_W-1 -: HI_CODE_W] = wr_word[HI_CODE_LSB +: HI_CODE_W];
        pend_nx = 1'b0;
      end
      default: ;
    endcase
  end

  assign upd_en = wr_stb | clr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      code_q <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      addr_q <= addr_nx;
      code_q <= code_nx;
      pend_q <= pend_nx;
    end
  end
endmodule

// File: rtl/cmdport_reg_port.sv
module cmdport_reg_port
  import cmdport_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  word_kind_e        kind,
  input  logic [WORD_W-1:0] wr_word,
  output regwr_t            rw_q
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NUM_REGS);

  logic [IDX_W-1:0] idx_w;
  logic             in_range;
  regwr_t           rw_nx;
  logic             upd_en;

  assign idx_w    = wr_word[IDX_LSB +: IDX_W];
  assign in_range = ({1'b0, idx_w} < LIMIT);

  always_comb begin
    rw_nx      = rw_q;
    rw_nx.we   = 1'b0;
    if (kind == WK_REGWR && in_range) begin
      rw_nx.we   = 1'b1;
      rw_nx.idx  = idx_w;
      rw_nx.data = wr_word[BYTE_W-1:0];
    end
  end

  // Only a live pulse or its end needs a register update
  assign upd_en = rw_q.we | (kind == WK_REGWR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= '0;
    end else if (upd_en) begin
      rw_q <= rw_nx;
    end
  end
endmodule

// File: rtl/cmdport_status.sv
module cmdport_status
  import cmdport_pkg::*;
(
  input  logic              empty,
  input  logic              full,
  output logic [WORD_W-1:0] stat
);
  always_comb begin
    stat = STAT_BASE;
    stat[EMPTY_BIT] = empty;
    stat[FULL_BIT]  = full;
  end
endmodule

// File: rtl/cmdport_decoder.sv
module cmdport_decoder
  import cmdport_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctl_wr,
  input  logic [WORD_W-1:0]         ctl_wdata,
  input  logic                      ctl_rd,
  input  logic                      dat_wr,
  input  logic                      dat_rd,
  input  logic                      fifo_empty,
  input  logic                      fifo_full,
  output logic [WORD_W-1:0]         stat_rdata,
  output logic                      reg_we,
  output logic [IDX_W-1:0]          reg_idx,
  output logic [BYTE_W-1:0]         reg_wdata,
  output logic [WORD_W-1:0]         acc_addr,
  output logic [CODE_W-1:0]         acc_code,
  output logic                      cmd_pending,
  output logic                      rd_zero
);
  logic       rst_core_n;
  logic       clr_stb;
  word_kind_e kind;
  regwr_t     rw;

  assign clr_stb = dat_wr | dat_rd | ctl_rd;

  cmdport_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cmdport_cmd_regs u_cmd (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_stb  (ctl_wr),
    .wr_word (ctl_wdata),
    .clr_stb (clr_stb),
    .kind    (kind),
    .addr_q  (acc_addr),
    .code_q  (acc_code),
    .pend_q  (cmd_pending)
  );

  cmdport_reg_port #(.NUM_REGS(NUM_REGS)) u_regp (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .kind    (kind),
    .wr_word (ctl_wdata),
    .rw_q    (rw)
  );

  cmdport_status u_stat (
    .empty (fifo_empty),
    .full  (fifo_full),
    .stat  (stat_rdata)
  );

  assign reg_we    = rw.we;
  assign reg_idx   = rw.idx;
  assign reg_wdata = rw.data;
  assign rd_zero   = dat_rd & acc_code[0];
endmodule

// File: rtl/cmdport_decoder_chk.sv
module cmdport_decoder_chk #(
  parameter int NUM_REGS = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_wr,
  input logic [15:0] ctl_wdata,
  input logic        ctl_rd,
  input logic        dat_wr,
  input logic        dat_rd,
  input logic        fifo_empty,
  input logic        fifo_full,
  input logic [15:0] stat_rdata,
  input logic        reg_we,
  input logic [4:0]  reg_idx,
  input logic [7:0]  reg_wdata,
  input logic [15:0] acc_addr,
  input logic [5:0]  acc_code,
  input logic        cmd_pending,
  input logic        rd_zero
);
  logic clr;
  logic idle_eff;
  logic regw_word;
  logic idx_ok;

  assign clr       = dat_wr | dat_rd | ctl_rd;
  assign idle_eff  = !cmd_pending || clr;
  assign regw_word = ctl_wr && idle_eff && (ctl_wdata[15:14] == 2'b10);
  assign idx_ok    = ({1'b0, ctl_wdata[12:8]} < 6'(NUM_REGS));

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> acc_addr == 16'h0 && acc_code == 6'h0 && !cmd_pending);

  p_regwr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    regw_word && idx_ok |=> reg_we && reg_idx == $past(ctl_wdata[12:8]) && reg_wdata == $past(ctl_wdata[7:0]));

  p_regwr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && !regw_word |=> !reg_we);

  p_bad_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    regw_word && !idx_ok |=> !reg_we);

  p_regwr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regw_word |=> !cmd_pending && $stable(acc_addr) && $stable(acc_code));

  p_first_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && idle_eff && ctl_wdata[15:14] != 2'b10 |=>
      cmd_pending && acc_addr[13:0] == $past(ctl_wdata[13:0]) && acc_code[1:0] == $past(ctl_wdata[15:14])
      && acc_addr[15:14] == $past(acc_addr[15:14]) && acc_code[5:2] == $past(acc_code[5:2]));

  p_second_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && cmd_pending && !clr |=>
      !cmd_pending && acc_addr[15:14] == $past(ctl_wdata[1:0]) && acc_code[5:2] == $past(ctl_wdata[7:4])
      && acc_addr[13:0] == $past(acc_addr[13:0]) && acc_code[1:0] == $past(acc_code[1:0]));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !ctl_wr |=> !cmd_pending && $stable(acc_addr) && $stable(acc_code));

  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && clr && cmd_pending |=> cmd_pending == ($past(ctl_wdata[15:14]) != 2'b10));

  always_comb begin
    if (rst_n) begin
      p_status_r9: assert (stat_rdata[9] == fifo_empty && stat_rdata[8] == fifo_full
                           && (stat_rdata & 16'hFCFF) == 16'h3400);
      p_rd_zero_r10: assert (rd_zero == (dat_rd && acc_code[0]));
    end
  end
endmodule

bind cmdport_decoder cmdport_decoder_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .ctl_wr      (ctl_wr),
  .ctl_wdata   (ctl_wdata),
  .ctl_rd      (ctl_rd),
  .dat_wr      (dat_wr),
  .dat_rd      (dat_rd),
  .fifo_empty  (fifo_empty),
  .fifo_full   (fifo_full),
  .stat_rdata  (stat_rdata),
  .reg_we      (reg_we),
  .reg_idx     (reg_idx),
  .reg_wdata   (reg_wdata),
  .acc_addr    (acc_addr),
  .acc_code    (acc_code),
  .cmd_pending (cmd_pending),
  .rd_zero     (rd_zero)
);

// File: tb/cmdport_decoder_bench.sv
`timescale 1ns/1ps
module cmdport_decoder_bench;
  localparam int NREG = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, ctl_rd, dat_wr, dat_rd, fifo_empty, fifo_full;
  logic [15:0] ctl_wdata;
  logic [15:0] stat_rdata;
  logic        reg_we;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_wdata;
  logic [15:0] acc_addr;
  logic [5:0]  acc_code;
  logic        cmd_pending;
  logic        rd_zero;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] m_addr;
  logic [5:0]  m_code;
  logic        m_pend;

  always #2 clk = ~clk;

  cmdport_decoder #(.NUM_REGS(NREG)) u_cmdport_decoder (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .stat_rdata(stat_rdata), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .acc_addr(acc_addr), .acc_code(acc_code), .cmd_pending(cmd_pending), .rd_zero(rd_zero)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_stat(input logic e, input logic f);
    return 16'h3400 | (e ? 16'h0200 : 16'h0) | (f ? 16'h0100 : 16'h0);
  endfunction

  // One cycle: drive, check combinational outputs, clock, check registered outputs
  task automatic step(input logic cw, input logic [15:0] wd, input logic crd,
                      input logic dw, input logic dr, input logic fe, input logic ff);
    logic clr, pe, e_we;
    logic [4:0] e_idx;
    logic [7:0] e_dat;
    ctl_wr = cw; ctl_wdata = wd; ctl_rd = crd; dat_wr = dw; dat_rd = dr;
    fifo_empty = fe; fifo_full = ff;
    #1;
    chk(stat_rdata == exp_stat(fe, ff), "R9 status", stat_rdata, exp_stat(fe, ff));
    chk(rd_zero == (dr & m_code[0]), "R10 rd_zero", rd_zero, dr & m_code[0]);
    clr = crd | dw | dr;
    pe = m_pend & ~clr;
    e_we = 1'b0; e_idx = wd[12:8]; e_dat = wd[7:0];
    m_pend = pe;
    if (cw) begin
      if (pe) begin
        m_addr[15:14] = wd[1:0];
        m_code[5:2]   = wd[7:4];
        m_pend = 1'b0;
      end else if (wd[15:14] == 2'b10) begin
        e_we = (wd[12:8] < NREG);
      end else begin
        m_addr[13:0] = wd[13:0];
        m_code[1:0]  = wd[15:14];
        m_pend = 1'b1;
      end
    end
    @(posedge clk); #1;
    chk(reg_we == e_we, "R2/R3/R8 reg_we", reg_we, e_we);
    if (e_we) begin
      chk(reg_idx == e_idx, "R2 reg_idx", reg_idx, e_idx);
      chk(reg_wdata == e_dat, "R2 reg_wdata", reg_wdata, e_dat);
    end
    chk(acc_addr == m_addr, "R4/R5/R6/R7 acc_addr", acc_addr, m_addr);
    chk(acc_code == m_code, "R4/R5/R6/R7 acc_code", acc_code, m_code);
    chk(cmd_pending == m_pend, "R5/R6/R7/R8 cmd_pending", cmd_pending, m_pend);
    ctl_wr = 0; ctl_rd = 0; dat_wr = 0; dat_rd = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ctl_wr = 0; ctl_wdata = '0; ctl_rd = 0; dat_wr = 0; dat_rd = 0;
    fifo_empty = 1; fifo_full = 0;
    m_addr = '0; m_code = '0; m_pend = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(acc_addr == 16'h0, "R1 acc_addr", acc_addr, 0);
    chk(acc_code == 6'h0, "R1 acc_code", acc_code, 0);
    chk(cmd_pending == 1'b0, "R1 cmd_pending", cmd_pending, 0);
    chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);

    // R2 register writes, edge index 23
    step(1, 16'h8A5C, 0, 0, 0, 1, 0);
    step(1, 16'h97FF, 0, 0, 0, 0, 1);
    step(0, 16'h0000, 0, 0, 0, 0, 0);     // R2 pulse ends
    // R3 out-of-range indices 24 and 31
    step(1, 16'h9811, 0, 0, 0, 1, 1);
    step(1, 16'h9FEE, 0, 0, 0, 0, 0);
    // R5 first word, then R4 is only reachable idle: complete command first
    step(1, 16'h4123, 0, 0, 0, 0, 0);
    // R6 second word carrying a 10 prefix
    step(1, 16'h80F2, 0, 0, 0, 0, 0);
    // R4 register write leaves address and code alone
    step(1, 16'h8133, 0, 0, 0, 0, 0);
    // R10 read with code bit 0 set
    step(0, 16'h0000, 0, 0, 1, 0, 0);
    // R7 clear by each access kind
    step(1, 16'hC3FF, 0, 0, 0, 0, 0);
    step(0, 16'h0000, 0, 1, 0, 0, 0);
    step(1, 16'h0001, 0, 0, 0, 0, 0);
    step(0, 16'h0000, 1, 0, 0, 1, 0);
    step(1, 16'h3FFF, 0, 0, 0, 0, 0);
    step(0, 16'h0000, 0, 0, 1, 0, 0);
    // R8 collisions while pending
    step(1, 16'h2222, 0, 0, 0, 0, 0);
    step(1, 16'h4444, 0, 0, 1, 0, 0);     // re-decoded as first word
    step(1, 16'h8312, 1, 0, 0, 0, 0);     // re-decoded as register write
    step(1, 16'h0000, 0, 0, 0, 0, 0);
    step(1, 16'h9A01, 0, 1, 0, 0, 0);     // R8 with R3 index 26

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      w = 16'($urandom);
      if (($urandom % 3) == 0) w[15:14] = 2'b10;
      step(($urandom % 4) != 0, w, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 6) == 0, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule